// File: doc/BRIEF.md
# USB Interrupt Status and Enable Unit

This unit collects event indications from a USB host/device controller core and turns them into one interrupt line for software. Every source owns a sticky bit in a status register and a bit at the same position in an enable register. Pulse-type sources set their bit on a one-cycle strobe. Two level-type sources, the bus suspend state and the PHY link state, set their bit whenever the level changes in either direction. Software reads both registers through a small 32-bit port, and clears status bits by writing ones.

Sources fall into two timing classes. Immediate sources drive the interrupt as soon as their status and enable bits are both set. Threshold-gated sources (transfer done, bus error, async advance) stay pending until a one-cycle threshold tick comes from an external timer. After the tick the interrupt remains asserted until no enabled gated bit is left. A host/device mode input removes the sources that have no meaning in the current role.

Top module: `usb_irq_unit`

## Requirements
- R1: After reset both registers read zero and `irq` is low.
- R2: A strobe on an active source sets its status bit, readable on the following cycle. The bit stays set until software clears it.
- R3: Writing the status register (`reg_sel`=0) clears each bit written as one and leaves every bit written as zero unchanged.
- R4: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R5: The immediate sources are bit 2 port change, bit 3 frame rollover, bit 4 system error, bit 7 reset received, bit 8 start-of-frame, bit 9 suspend change and bit 11 link-state change. Each raises `irq` in the cycle after its status bit is set, if its enable bit (`reg_sel`=1) is one, and never while the enable bit is zero.
- R6: The gated sources are bit 0 transfer done, bit 1 bus error and bit 5 async advance. An enabled gated bit raises `irq` only in the cycle after a `thr_tick` that finds it set. A tick that comes with nothing pending has no effect. Once raised, `irq` holds until no enabled gated bit remains.
- R7: Any edge, rising or falling, on `suspend_lvl` sets bit 9, and any edge on `ulpi_lvl` sets bit 11. A steady level sets nothing, and strobes on `evt_strobe` bits 9 and 11 are ignored.
- R8: With `host_mode`=1, bits 7 and 9 are held at zero. With `host_mode`=0, bits 3 and 5 are held at zero. Bits that no longer apply are cleared when the mode changes.
- R9: Bits 6, 10 and 12 to 31 of both registers always read zero. Writes and strobes at those positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| evt_strobe | input | 12 | One-cycle event strobes, one per status bit position |
| suspend_lvl | input | 1 | Suspend level; edges set bit 9 |
| ulpi_lvl | input | 1 | PHY link-state level; edges set bit 11 |
| thr_tick | input | 1 | One-cycle interrupt-threshold tick |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take `thr_tick` and the event strobes to be synchronous one-cycle pulses. They take the two level inputs to be already synchronised to `clk`. They also take it that `host_mode` changes only between register accesses. The stimulus drives every input on the falling edge, keeps each strobe high for exactly one cycle and changes the mode only while the register port is idle. It then samples results one falling edge after the rising edge that captured them.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int SRC_N = 12;

    // bit positions decoded by software
    localparam int B_XFER   = 0;
    localparam int B_BUSERR = 1;
    localparam int B_PORT   = 2;
    localparam int B_FROLL  = 3;
    localparam int B_SYSERR = 4;
    localparam int B_ASYNC  = 5;
    localparam int B_RESET  = 7;
    localparam int B_SOF    = 8;
    localparam int B_SUSP   = 9;
    localparam int B_LINK   = 11;

    localparam logic [SRC_N-1:0] THR_MASK  = 12'h023;
    localparam logic [SRC_N-1:0] IMM_MASK  = 12'hB9C;
    localparam logic [SRC_N-1:0] IMPL_MASK = THR_MASK | IMM_MASK;
    localparam logic [SRC_N-1:0] LVL_MASK  = 12'hA00;
    localparam logic [SRC_N-1:0] PULSE_MASK = IMPL_MASK & ~LVL_MASK;
    localparam logic [SRC_N-1:0] HOST_ONLY = 12'h028;
    localparam logic [SRC_N-1:0] DEV_ONLY  = 12'h280;
    localparam logic [SRC_N-1:0] HOST_KEEP = IMPL_MASK & ~DEV_ONLY;
    localparam logic [SRC_N-1:0] DEV_KEEP  = IMPL_MASK & ~HOST_ONLY;

endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge #(
    parameter int NLVL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] lvl_i,
    output logic [NLVL-1:0] chg_o
);
    typedef struct packed {
        logic [NLVL-1:0] lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        assign chg_o[g] = lvl_i[g] ^ st_q.lvl[g];

        // R7
        edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chg_o[g] |=> (st_q.lvl[g] != $past(st_q.lvl[g])));
    end

endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
    parameter int NSRC = usb_irq_pkg::SRC_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] keep_i,
    output logic [NSRC-1:0] sts_q_o,
    output logic [NSRC-1:0] sts_d_o
);
    typedef struct packed {
        logic [NSRC-1:0] sts;
    } sts_st_t;

    sts_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // set is OR-ed after the clear, so a same-cycle set survives
        st_d.sts = ((st_q.sts & ~clr_i) | set_i) & keep_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q_o = st_q.sts;
    assign sts_d_o = st_d.sts;

    // R2
    set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & keep_i)) |=>
        ((st_q.sts & $past(set_i & keep_i)) == $past(set_i & keep_i)));

    // R3
    wr_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=>
        ((($past(st_q.sts) & ~$past(clr_i) & $past(keep_i)) & ~st_q.sts) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i & keep_i)) |=>
        ((st_q.sts & $past(set_i & clr_i & keep_i)) != '0));

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate #(
    parameter int              NSRC     = usb_irq_pkg::SRC_N,
    parameter logic [NSRC-1:0] THR_M    = usb_irq_pkg::THR_MASK,
    parameter logic [NSRC-1:0] IMM_M    = usb_irq_pkg::IMM_MASK,
    parameter logic [NSRC-1:0] EN_M     = usb_irq_pkg::IMPL_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_wdata_i,
    input  logic [NSRC-1:0] sts_q_i,
    input  logic [NSRC-1:0] sts_d_i,
    input  logic            tick_i,
    output logic [NSRC-1:0] en_q_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic            fire;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     thr_now;
    logic     thr_next;

    always_comb begin
        st_d     = st_q;
        if (en_wr_i) st_d.en = en_wdata_i & EN_M;
        thr_now  = |(sts_q_i & st_q.en & THR_M);
        thr_next = |(sts_d_i & st_d.en & THR_M);
        st_d.fire = thr_next & (st_q.fire | (tick_i & thr_now));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q_o = st_q.en;
    assign irq_o  = (|(sts_q_i & st_q.en & IMM_M)) | st_q.fire;

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(sts_q_i & st_q.en)));

    // R6
    thr_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fire) |-> $past(tick_i));

    // R6
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> (|(sts_q_i & st_q.en & THR_M)));

endmodule

// File: rtl/usb_irq_unit.sv
module usb_irq_unit
    import usb_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [SRC_N-1:0] evt_strobe,
    input  logic             suspend_lvl,
    input  logic             ulpi_lvl,
    input  logic             thr_tick,
    output logic             irq
);
    localparam int NLVL = 2;
    localparam int PAD  = REG_W - SRC_N;

    logic [NLVL-1:0]  lvl_chg;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] keep_vec;
    logic [SRC_N-1:0] sts_q;
    logic [SRC_N-1:0] sts_d;
    logic [SRC_N-1:0] en_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[REG_W-1:SRC_N];

    usb_irq_edge #(.NLVL(NLVL)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({ulpi_lvl, suspend_lvl}),
        .chg_o (lvl_chg)
    );

    always_comb begin
        set_vec         = evt_strobe & PULSE_MASK;
        set_vec[B_SUSP] = lvl_chg[0];
        set_vec[B_LINK] = lvl_chg[1];
        clr_vec         = (reg_wr && !reg_sel) ? reg_wdata[SRC_N-1:0] : '0;
        keep_vec        = host_mode ? HOST_KEEP : DEV_KEEP;
    end

    usb_irq_status #(.NSRC(SRC_N)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .keep_i  (keep_vec),
        .sts_q_o (sts_q),
        .sts_d_o (sts_d)
    );

    usb_irq_gate #(.NSRC(SRC_N)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr_i    (reg_wr && reg_sel),
        .en_wdata_i (reg_wdata[SRC_N-1:0]),
        .sts_q_i    (sts_q),
        .sts_d_i    (sts_d),
        .tick_i     (thr_tick),
        .en_q_o     (en_q),
        .irq_o      (irq)
    );

    assign reg_rdata = {{PAD{1'b0}}, (reg_sel ? en_q : sts_q)};

    // R8
    mode_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_mode) |-> ((sts_q & DEV_ONLY) == '0));

    // R8
    mode_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_mode) |-> ((sts_q & HOST_ONLY) == '0));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q | en_q) & ~IMPL_MASK) == '0);

    // R7
    lvl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_chg[1] && keep_vec[B_LINK]) |=> sts_q[B_LINK]);

endmodule

// File: tb/tb_usb_irq_unit.sv
module tb_usb_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] evt_strobe = '0;
    logic        suspend_lvl = 1'b0;
    logic        ulpi_lvl = 1'b0;
    logic        thr_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_irq_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_mode   (host_mode),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt_strobe  (evt_strobe),
        .suspend_lvl (suspend_lvl),
        .ulpi_lvl    (ulpi_lvl),
        .thr_tick    (thr_tick),
        .irq         (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [11:0] v);
        evt_strobe = v;
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic tick();
        thr_tick = 1'b1;
        @(negedge clk);
        thr_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk(v, 32'h0, "R1 status after reset");
        rd(1'b1, v); chk(v, 32'h0, "R1 enable after reset");
        chk({31'b0, irq}, 32'h0, "R1 irq after reset");
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        pulse(12'h004);
        rd(1'b0, v); chk(v, 32'h4, "R2 status set by strobe");
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk(v, 32'h4, "R2 status stays set");
        chk({31'b0, irq}, 32'h0, "R5 no irq while disabled");
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(1'b1, 32'h4);
        chk({31'b0, irq}, 32'h1, "R5 irq when status and enable");
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk(v, 32'h4, "R3 write zero keeps bit");
        wr(1'b0, 32'h10);
        rd(1'b0, v); chk(v, 32'h4, "R3 write other bit keeps bit");
        wr(1'b0, 32'h4);
        rd(1'b0, v); chk(v, 32'h0, "R3 write one clears");
        chk({31'b0, irq}, 32'h0, "R5 irq drops after clear");
        wr(1'b1, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        evt_strobe = 12'h010;
        reg_sel = 1'b0; reg_wdata = 32'h10; reg_wr = 1'b1;
        @(negedge clk);
        evt_strobe = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(1'b0, v); chk(v, 32'h10, "R4 set beats clear");
        wr(1'b0, 32'h10);
    endtask

    task automatic t_thr();
        logic [31:0] v;
        wr(1'b1, 32'h2);
        tick();
        pulse(12'h002);
        rd(1'b0, v); chk(v, 32'h2, "R6 gated bit set");
        chk({31'b0, irq}, 32'h0, "R6 no irq before tick");
        repeat (4) @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R6 still waiting for tick");
        tick();
        chk({31'b0, irq}, 32'h1, "R6 irq after tick");
        repeat (3) @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R6 irq held");
        wr(1'b0, 32'h2);
        chk({31'b0, irq}, 32'h0, "R6 irq released on clear");
        wr(1'b1, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        host_mode = 1'b0;
        @(negedge clk);
        wr(1'b1, 32'hA00);
        ulpi_lvl = 1'b1; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h800, "R7 rising link edge");
        chk({31'b0, irq}, 32'h1, "R5 link change irq");
        wr(1'b0, 32'h800);
        repeat (2) @(negedge clk);
        rd(1'b0, v); chk(v, 32'h0, "R7 steady level no flag");
        ulpi_lvl = 1'b0; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h800, "R7 falling link edge");
        wr(1'b0, 32'h800);
        suspend_lvl = 1'b1; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h200, "R7 rising suspend edge");
        wr(1'b0, 32'h200);
        suspend_lvl = 1'b0; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h200, "R7 falling suspend edge");
        wr(1'b0, 32'h200);
        pulse(12'hA00);
        rd(1'b0, v); chk(v, 32'h0, "R7 strobes at level bits ignored");
        wr(1'b1, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        host_mode = 1'b1;
        @(negedge clk);
        pulse(12'h080);
        rd(1'b0, v); chk(v, 32'h0, "R8 device-only bit in host mode");
        pulse(12'h008);
        rd(1'b0, v); chk(v, 32'h8, "R8 host-only bit in host mode");
        host_mode = 1'b0; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h0, "R8 host bit cleared on mode change");
        pulse(12'h008);
        rd(1'b0, v); chk(v, 32'h0, "R8 host-only bit in device mode");
        host_mode = 1'b1; @(negedge clk);
        suspend_lvl = 1'b1; @(negedge clk);
        rd(1'b0, v); chk(v, 32'h0, "R8 suspend edge in host mode");
        suspend_lvl = 1'b0; @(negedge clk);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk(v, 32'h0000_0BBF, "R9 enable reserved bits");
        wr(1'b1, 32'h0);
        pulse(12'h440);
        rd(1'b0, v); chk(v, 32'h0, "R9 reserved strobes ignored");
        pulse(12'hFFF);
        rd(1'b0, v); chk(v, 32'h13F, "R9 all strobes host mode");
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk(v, 32'h0, "R3 clear all");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_w1c();
        t_set_wins();
        t_thr();
        t_level();
        t_mode();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule